// File: doc/BRIEF.md
# Pipeline Fetch Steering and Interlock Controller

This controller sits beside the datapath of a five-stage in-order 32-bit core (Fetch, Decode, Execute, Memory, Writeback). Each cycle it chooses the address that Fetch reads and raises the enables that either freeze the front of the pipe or replace stage contents with empty slots. Conditional branches are predicted not-taken and resolved in the Memory stage. Unconditional jumps are resolved in Execute. A load followed at once by an instruction that reads the loaded register holds the front end for one cycle.

The datapath presents a four-bit instruction class and a valid bit for the Decode, Execute and Memory stages. It also presents register indices, the branch outcome and target from Memory, and the jump target from Execute. The fetch address and all enables are combinational from these inputs and from one register holding the last fetched address.

A two-state machine governs start-up. `ST_BOOT` is the single cycle after reset. In it the fetch address is the reset vector and all redirects and stalls are masked. The boot-done transition always moves the machine to `ST_RUN`, which then holds until the next reset. In `ST_RUN` the address follows the priority stall, branch, jump, sequential.

Top module: `pipe_steer`

## Requirements
- R1: In the first cycle after reset, `fetch_pc` is 0x01000000 with nothing added, and `hold_fd`, `bubble_ex`, `kill_de` and `kill_ex` are low whatever the stage inputs are.
- R2: After the first cycle, with no stall and no redirect, `fetch_pc` is the previous cycle's `fetch_pc` plus 4.
- R3: A valid Memory-stage instruction of class 5 (branch) with `mem_taken` high sets `fetch_pc` to `mem_target` and raises both `kill_de` and `kill_ex`. This takes precedence over a jump in Execute.
- R4: A valid Execute-stage instruction of class 3 (JAL) or 4 (JALR), with no taken branch in Memory, sets `fetch_pc` to `ex_target` and raises `kill_de` only.
- R5: A load-use hazard occurs when Execute holds a valid class 6 (load) with nonzero `ex_rd` equal to a source that a valid Decode instruction uses. On such a hazard `hold_fd` and `bubble_ex` are high and `fetch_pc` equals the previous `fetch_pc`.
- R6: Decode source use by class uses the encoding 0 NOP, 1 LUI, 2 AUIPC, 3 JAL, 4 JALR, 5 branch, 6 load, 7 store, 8 ALU-immediate, 9 ALU-register, 10 ECALL, 11-15 unused. rs1 is used by classes 4-9. rs2 is used by classes 5, 7 and 9. `ex_rd` of 0 never stalls.
- R7: When a taken branch redirect and a load-use hazard coincide, the redirect wins: `hold_fd` and `bubble_ex` stay low.
- R8: `de_reg_we` is high only for a valid Decode instruction of class 1, 2, 3, 4, 6, 8 or 9. `de_mem_we` is high only for a valid class 7.
- R9: An instruction with its valid bit low, in Execute or Memory, causes no redirect and no stall.
- R10: A valid branch in Memory with `mem_taken` low leaves fetch sequential and raises no kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_valid | input | 1 | Decode stage holds a real instruction |
| de_class | input | 4 | Decode instruction class |
| de_rs1 | input | 5 | Decode first source index |
| de_rs2 | input | 5 | Decode second source index |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_class | input | 4 | Execute instruction class |
| ex_rd | input | 5 | Execute destination index |
| ex_target | input | 32 | Jump target computed in Execute |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_class | input | 4 | Memory instruction class |
| mem_taken | input | 1 | Branch condition true in Memory |
| mem_target | input | 32 | Branch target computed earlier |
| fetch_pc | output | 32 | Address fetched this cycle |
| hold_fd | output | 1 | Freeze Fetch and Decode registers |
| bubble_ex | output | 1 | Load an empty slot into Execute |
| kill_de | output | 1 | Replace Decode with an empty slot |
| kill_ex | output | 1 | Replace Execute with an empty slot |
| de_reg_we | output | 1 | Register write enable for the Decode instruction |
| de_mem_we | output | 1 | Memory write enable for the Decode instruction |

## Verification
The hardest situation to reach is a load-use hazard that meets a taken branch in the same cycle. It needs three stages filled consistently at once, and it must show that the kill suppresses the stall without losing the redirect. The bench drives every stage's inputs directly rather than pushing an instruction stream. This lets it sweep all valid, class and taken combinations against a loaded register that matches the Decode sources. The last-fetched address is tracked arithmetically, so a stall that wrongly holds or advances the fetch address shows up on the following cycle.

// File: rtl/pipe_steer_pkg.sv
package pipe_steer_pkg;

    typedef enum logic [3:0] {
        CL_NOP    = 4'd0,
        CL_LUI    = 4'd1,
        CL_AUIPC  = 4'd2,
        CL_JAL    = 4'd3,
        CL_JALR   = 4'd4,
        CL_BRANCH = 4'd5,
        CL_LOAD   = 4'd6,
        CL_STORE  = 4'd7,
        CL_OPIMM  = 4'd8,
        CL_OPREG  = 4'd9,
        CL_SYSTEM = 4'd10
    } iclass_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } steer_state_e;

    localparam int CLASS_W = 4;

endpackage

// File: rtl/steer_src_use.sv
module steer_src_use
    import pipe_steer_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    input  logic               valid,
    output logic               use_rs1,
    output logic               use_rs2,
    output logic               reg_we,
    output logic               mem_we
);
    always_comb begin
        use_rs1 = 1'b0;
        use_rs2 = 1'b0;
        reg_we  = 1'b0;
        mem_we  = 1'b0;
        case (cls)
            CL_LUI, CL_AUIPC, CL_JAL: reg_we = 1'b1;
            CL_JALR, CL_LOAD, CL_OPIMM: begin
                use_rs1 = 1'b1;
                reg_we  = 1'b1;
            end
            CL_BRANCH: begin
                use_rs1 = 1'b1;
                use_rs2 = 1'b1;
            end
            CL_STORE: begin
                use_rs1 = 1'b1;
                use_rs2 = 1'b1;
                mem_we  = 1'b1;
            end
            CL_OPREG: begin
                use_rs1 = 1'b1;
                use_rs2 = 1'b1;
                reg_we  = 1'b1;
            end
            default: ;
        endcase
        if (!valid) begin
            use_rs1 = 1'b0;
            use_rs2 = 1'b0;
            reg_we  = 1'b0;
            mem_we  = 1'b0;
        end
    end
endmodule

// File: rtl/steer_interlock.sv
module steer_interlock
    import pipe_steer_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic                   ex_valid,
    input  logic [CLASS_W-1:0]     ex_cls,
    input  logic [REG_AW-1:0]      ex_rd,
    input  logic [NSRC-1:0]        src_used,
    input  logic [NSRC*REG_AW-1:0] src_idx,
    output logic                   load_use
);
    logic             producer;
    logic [NSRC-1:0]  hit;

    assign producer = ex_valid && (ex_cls == CL_LOAD) && (ex_rd != '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_used[g] && (src_idx[g*REG_AW +: REG_AW] == ex_rd);
    end

    assign load_use = producer && (|hit);
endmodule

// File: rtl/steer_pc_sel.sv
module steer_pc_sel #(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  PC_RESET = 32'h0100_0000,
    parameter int               PC_STEP  = 4
) (
    input  logic            boot,
    input  logic            stall,
    input  logic            br_redirect,
    input  logic            jmp_redirect,
    input  logic [XLEN-1:0] last_pc,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] jmp_target,
    output logic [XLEN-1:0] next_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    always_comb begin
        if (boot)              next_pc = PC_RESET;
        else if (stall)        next_pc = last_pc;
        else if (br_redirect)  next_pc = br_target;
        else if (jmp_redirect) next_pc = jmp_target;
        else                   next_pc = last_pc + STEP;
    end
endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
    import pipe_steer_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              REG_AW   = 5,
    parameter logic [XLEN-1:0] PC_RESET = 32'h0100_0000,
    parameter int              PC_STEP  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               de_valid,
    input  logic [3:0]         de_class,
    input  logic [REG_AW-1:0]  de_rs1,
    input  logic [REG_AW-1:0]  de_rs2,
    input  logic               ex_valid,
    input  logic [3:0]         ex_class,
    input  logic [REG_AW-1:0]  ex_rd,
    input  logic [XLEN-1:0]    ex_target,
    input  logic               mem_valid,
    input  logic [3:0]         mem_class,
    input  logic               mem_taken,
    input  logic [XLEN-1:0]    mem_target,
    output logic [XLEN-1:0]    fetch_pc,
    output logic               hold_fd,
    output logic               bubble_ex,
    output logic               kill_de,
    output logic               kill_ex,
    output logic               de_reg_we,
    output logic               de_mem_we
);
    steer_state_e    state, state_nx;
    logic [XLEN-1:0] pc_q;
    logic            run_en;
    logic            use1, use2, load_use;
    logic            br_go, jmp_go, stall;

    steer_src_use i_use (
        .cls     (de_class),
        .valid   (de_valid),
        .use_rs1 (use1),
        .use_rs2 (use2),
        .reg_we  (de_reg_we),
        .mem_we  (de_mem_we)
    );

    steer_interlock #(.REG_AW(REG_AW), .NSRC(2)) i_lock (
        .ex_valid (ex_valid),
        .ex_cls   (ex_class),
        .ex_rd    (ex_rd),
        .src_used ({use2, use1}),
        .src_idx  ({de_rs2, de_rs1}),
        .load_use (load_use)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            pc_q  <= PC_RESET;
        end else begin
            state <= state_nx;
            pc_q  <= fetch_pc;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        run_en = 1'b0;
        unique case (state)
            ST_BOOT: run_en = 1'b0;
            ST_RUN:  run_en = 1'b1;
        endcase
        br_go  = run_en && mem_valid && (mem_class == CL_BRANCH) && mem_taken;
        jmp_go = run_en && ex_valid && ((ex_class == CL_JAL) || (ex_class == CL_JALR));
        stall  = run_en && load_use && !br_go && !jmp_go;
        hold_fd   = stall;
        bubble_ex = stall;
        kill_de   = br_go || jmp_go;
        kill_ex   = br_go;
    end

    steer_pc_sel #(.XLEN(XLEN), .PC_RESET(PC_RESET), .PC_STEP(PC_STEP)) i_pc (
        .boot         (!run_en),
        .stall        (stall),
        .br_redirect  (br_go),
        .jmp_redirect (jmp_go),
        .last_pc      (pc_q),
        .br_target    (mem_target),
        .jmp_target   (ex_target),
        .next_pc      (fetch_pc)
    );
endmodule

// File: rtl/pipe_steer_chk.sv
module pipe_steer_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] PC_RESET = 32'h0100_0000,
    parameter int              PC_STEP  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st,
    input logic            de_valid,
    input logic            ex_valid,
    input logic            mem_valid,
    input logic [XLEN-1:0] fetch_pc,
    input logic            hold_fd,
    input logic            bubble_ex,
    input logic            kill_de,
    input logic            kill_ex,
    input logic            de_reg_we,
    input logic            de_mem_we
);
    // R1: boot cycle fetches the reset vector with all controls low
    a_r1_boot_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b0) |-> (fetch_pc == PC_RESET && !hold_fd && !kill_de));

    // R2: sequential advance
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && !hold_fd && !kill_de) |->
            (fetch_pc == $past(fetch_pc) + XLEN'(PC_STEP)));

    // R3: branch kill covers Decode as well
    a_r3_kill_pair: assert property (@(posedge clk) disable iff (!rst_n)
        kill_ex |-> kill_de);

    // R5: stall freezes the fetch address and bubbles Execute
    a_r5_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && hold_fd) |-> (fetch_pc == $past(fetch_pc) && bubble_ex));

    // R7: kill and stall never together
    a_r7_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kill_de |-> (!hold_fd && !bubble_ex));

    // R8: empty Decode slot writes nothing
    a_r8_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !de_valid |-> (!de_reg_we && !de_mem_we));

    // R9: empty later stages cause no redirect
    a_r9_no_ghost: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid && !mem_valid) |-> (!kill_de && !hold_fd));
endmodule

bind pipe_steer pipe_steer_chk #(.XLEN(XLEN), .PC_RESET(PC_RESET), .PC_STEP(PC_STEP)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state),
    .de_valid  (de_valid),
    .ex_valid  (ex_valid),
    .mem_valid (mem_valid),
    .fetch_pc  (fetch_pc),
    .hold_fd   (hold_fd),
    .bubble_ex (bubble_ex),
    .kill_de   (kill_de),
    .kill_ex   (kill_ex),
    .de_reg_we (de_reg_we),
    .de_mem_we (de_mem_we)
);

// File: tb/test_pipe_steer.sv
module test_pipe_steer;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC     = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de_valid = 0, ex_valid = 0, mem_valid = 0, mem_taken = 0;
    logic [3:0]  de_class = 0, ex_class = 0, mem_class = 0;
    logic [4:0]  de_rs1 = 0, de_rs2 = 0, ex_rd = 0;
    logic [31:0] ex_target = 0, mem_target = 0;
    logic [31:0] fetch_pc;
    logic        hold_fd, bubble_ex, kill_de, kill_ex, de_reg_we, de_mem_we;

    int total = 0;
    int bad   = 0;
    logic        m_boot = 1'b1;
    logic [31:0] m_last = RST_PC;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_steer i_pipe_steer (
        .clk(clk), .rst_n(rst_n),
        .de_valid(de_valid), .de_class(de_class), .de_rs1(de_rs1), .de_rs2(de_rs2),
        .ex_valid(ex_valid), .ex_class(ex_class), .ex_rd(ex_rd), .ex_target(ex_target),
        .mem_valid(mem_valid), .mem_class(mem_class), .mem_taken(mem_taken),
        .mem_target(mem_target),
        .fetch_pc(fetch_pc), .hold_fd(hold_fd), .bubble_ex(bubble_ex),
        .kill_de(kill_de), .kill_ex(kill_ex), .de_reg_we(de_reg_we), .de_mem_we(de_mem_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic u1(input logic [3:0] c);
        return (c >= 4 && c <= 9);
    endfunction
    function automatic logic u2(input logic [3:0] c);
        return (c == 5 || c == 7 || c == 9);
    endfunction
    function automatic logic wr(input logic [3:0] c);
        return (c == 1 || c == 2 || c == 3 || c == 4 || c == 6 || c == 8 || c == 9);
    endfunction

    // Check all outputs for the inputs driven now, then advance one clock.
    task automatic step(input string tag);
        logic br, jp, lu, st;
        logic [31:0] pc;
        #1;
        br = !m_boot && mem_valid && mem_class == 4'd5 && mem_taken;
        jp = !m_boot && ex_valid && (ex_class == 4'd3 || ex_class == 4'd4);
        lu = !m_boot && ex_valid && ex_class == 4'd6 && ex_rd != 0 && de_valid &&
             ((u1(de_class) && de_rs1 == ex_rd) || (u2(de_class) && de_rs2 == ex_rd));
        st = lu && !br && !jp;
        pc = m_boot ? RST_PC : st ? m_last : br ? mem_target : jp ? ex_target : m_last + 32'd4;
        chk({tag, " fetch_pc"}, fetch_pc, pc);
        chk({tag, " hold_fd"},  {31'd0, hold_fd},   {31'd0, st});
        chk({tag, " bubble_ex"},{31'd0, bubble_ex}, {31'd0, st});
        chk({tag, " kill_de"},  {31'd0, kill_de},   {31'd0, br || jp});
        chk({tag, " kill_ex"},  {31'd0, kill_ex},   {31'd0, br});
        chk({tag, " de_reg_we"},{31'd0, de_reg_we}, {31'd0, de_valid && wr(de_class)});
        chk({tag, " de_mem_we"},{31'd0, de_mem_we}, {31'd0, de_valid && de_class == 4'd7});
        @(posedge clk);
        m_last = pc;
        m_boot = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        de_valid = 0; ex_valid = 0; mem_valid = 0; mem_taken = 0;
        de_class = 0; ex_class = 0; mem_class = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: hostile inputs during the boot cycle are masked
        rst_n = 1'b1; m_boot = 1'b1; m_last = RST_PC;
        mem_valid = 1; mem_class = 5; mem_taken = 1; mem_target = 32'h0000_4000;
        ex_valid = 1; ex_class = 3; ex_target = 32'h0000_8000;
        step("R1 boot");
        idle();
        // R2: sequential fetch
        for (int i = 0; i < 6; i++) step("R2 seq");

        // R5/R6: load-use sweep over every Decode class and register pattern
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 4; r++)
                for (int p = 0; p < 4; p++) begin
                    logic [4:0] rd;
                    rd = (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : (r == 2) ? 5'd17 : 5'd31;
                    ex_valid = 1; ex_class = 6; ex_rd = rd;
                    de_valid = 1; de_class = c[3:0];
                    de_rs1 = (p == 0 || p == 2) ? rd : rd ^ 5'd3;
                    de_rs2 = (p == 1 || p == 2) ? rd : rd ^ 5'd6;
                    step("R5 R6 interlock");
                end
        idle();

        // R3/R4/R7/R9/R10: redirect combinations with a pending load-use
        for (int k = 0; k < 64; k++) begin
            mem_valid = k[0]; mem_class = k[1] ? 4'd5 : 4'd6; mem_taken = k[2];
            mem_target = 32'h0200_0000 + 32'(k) * 32'd16;
            ex_valid = k[3];
            ex_class = k[4] ? (k[5] ? 4'd4 : 4'd3) : 4'd6;
            ex_target = 32'h0300_0000 + 32'(k) * 32'd8;
            ex_rd = 5'd9; de_valid = 1; de_class = 4'd9; de_rs1 = 5'd9; de_rs2 = 5'd2;
            step("R3 R4 R7 R9 R10 redirect");
        end
        idle();

        // R8: write enables by class and valid
        for (int c = 0; c < 16; c++)
            for (int v = 0; v < 2; v++) begin
                de_valid = v[0]; de_class = c[3:0];
                step("R8 write enables");
            end
        idle();

        // R1: a second reset mid-run restarts at the vector
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; m_boot = 1'b1; m_last = RST_PC;
        step("R1 rerun");
        step("R2 after rerun");
        finish_run();
    end
endmodule